// File: doc/BRIEF.md
# Eight-Source Peripheral Interrupt Status Block

This block collects eight interrupt conditions from one peripheral and turns them into a single summary interrupt. Each source is programmed as level or edge triggered, with two polarity bits whose meaning depends on that mode. The block keeps three bitmaps: the live condition of every source, the latched condition and the enable mask. All of them are reached through a byte-wide register port with an address, write data, a write strobe, a read strobe and registered read data.

Software never writes the enable or latch bitmaps directly. It sets enables with one write-one register, clears them with another and clears latches with a third. A longer transfer is a run of single-byte accesses at rising addresses. Two such runs matter to software. The first writes the trigger mode and both polarity maps in one go. The second clears stale latches just before the matching enable is set, so enabling a source cannot raise an old event.

Top module: `pirq_status`

## Requirements
- R1: After reset the enable, trigger-mode, high-polarity, low-polarity and latch bitmaps are all zero, `irq_out` is low and `bus_rdata` is zero.
- R2: Offsets 0x11 (trigger mode, 1 = edge, 0 = level), 0x12 (high polarity) and 0x13 (low polarity) are written on a write strobe and read back unchanged. In every register, bit n belongs to source n.
- R3: A write to 0x15 sets the enable bit of each source whose data bit is 1. A write to 0x16 clears the enable bit of each source whose data bit is 1. Zero data bits leave enables unchanged. A read of 0x15 returns the enable bitmap.
- R4: Read data is registered. It holds the addressed value in the cycle after a read strobe and is zero in every other cycle. A read of 0x10 returns the input levels sampled one clock before the read edge.
- R5: An edge source latches on a rising input when its high-polarity bit is set and on a falling input when its low-polarity bit is set. With both bits set it latches on either edge, and with neither set it never latches. A latch becomes visible two clock edges after the input changes.
- R6: A level source latches while its input is high if its high-polarity bit is set, or while its input is low if its low-polarity bit is set. A latch clear has no effect while that level is still active.
- R7: A source whose enable bit is 0 does not latch. A latch taken before the source was disabled is kept.
- R8: Writing 1 to bit n of 0x14 clears latch n unless source n fires in the same cycle. A read of 0x18 returns the latch bitmap.
- R9: `irq_out` is high exactly when some source is both latched and enabled.
- R10: Reads of 0x14, 0x16 and of undefined offsets return zero. Writes to 0x10, 0x18 and undefined offsets change nothing.
- R11: Back-to-back writes at 0x14 then 0x15 clear a stale latch and then enable the source, and `irq_out` stays low throughout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_in | input | 8 | Raw source conditions, bit n = source n |
| bus_addr | input | 8 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe, one byte per cycle |
| bus_re | input | 1 | Read strobe, one byte per cycle |
| bus_rdata | output | 8 | Registered read data |
| irq_out | output | 1 | Summary interrupt |

## Verification
A register write takes effect at the clock edge where its strobe is high, so its result can be read back from the next cycle on. Read data is due one cycle after the read strobe. An input change reaches the live-status register at the first edge and the latch, and so `irq_out`, at the second. The bench drives the inputs on falling edges and runs a behavioural reference model on rising edges. It compares `irq_out` and `bus_rdata` against that model on every falling edge. Directed checks then wait three falling edges after each input change before they read, and compare against literal expected values.

// File: rtl/pirq_pkg.sv
package pirq_pkg;

  localparam logic [7:0] OFS_LIVE  = 8'h10;
  localparam logic [7:0] OFS_KIND  = 8'h11;
  localparam logic [7:0] OFS_PHI   = 8'h12;
  localparam logic [7:0] OFS_PLO   = 8'h13;
  localparam logic [7:0] OFS_ACK   = 8'h14;
  localparam logic [7:0] OFS_ON    = 8'h15;
  localparam logic [7:0] OFS_OFF   = 8'h16;
  localparam logic [7:0] OFS_HELD  = 8'h18;

  // Trigger condition of one source, before enable qualification.
  function automatic logic src_fire(input logic edge_mode, input logic hi,
                                    input logic lo, input logic cur,
                                    input logic prev);
    if (edge_mode)
      return (hi & cur & ~prev) | (lo & ~cur & prev);
    else
      return (hi & cur) | (lo & ~cur);
  endfunction

  // Next value of one latch bit: a new event wins over a clear.
  function automatic logic hold_next(input logic fire, input logic ack,
                                     input logic held);
    return fire | (held & ~ack);
  endfunction

endpackage

// File: rtl/pirq_regs.sv
module pirq_regs #(
  parameter int unsigned NSRC = 8,
  parameter int unsigned DW   = 8,
  parameter int unsigned AW   = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   addr,
  input  logic [DW-1:0]   wdata,
  input  logic            we,
  input  logic            re,
  input  logic [NSRC-1:0] live,
  input  logic [NSRC-1:0] held,
  output logic [DW-1:0]   rdata,
  output logic [NSRC-1:0] kind,
  output logic [NSRC-1:0] pol_hi,
  output logic [NSRC-1:0] pol_lo,
  output logic [NSRC-1:0] en,
  output logic [NSRC-1:0] ack
);
  import pirq_pkg::*;

  logic            wr_kind, wr_phi, wr_plo, wr_ack, wr_on, wr_off;
  logic [NSRC-1:0] wbits;
  logic [DW-1:0]   rd_next;

  assign wbits   = wdata[NSRC-1:0];
  assign wr_kind = we && (addr == AW'(OFS_KIND));
  assign wr_phi  = we && (addr == AW'(OFS_PHI));
  assign wr_plo  = we && (addr == AW'(OFS_PLO));
  assign wr_ack  = we && (addr == AW'(OFS_ACK));
  assign wr_on   = we && (addr == AW'(OFS_ON));
  assign wr_off  = we && (addr == AW'(OFS_OFF));

  assign ack = wr_ack ? wbits : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind   <= '0;
      pol_hi <= '0;
      pol_lo <= '0;
      en     <= '0;
    end else begin
      if (wr_kind) kind   <= wbits;
      if (wr_phi)  pol_hi <= wbits;
      if (wr_plo)  pol_lo <= wbits;
      if (wr_on)        en <= en | wbits;
      else if (wr_off)  en <= en & ~wbits;
    end
  end

  always_comb begin
    rd_next = '0;
    case (addr)
      AW'(OFS_LIVE): rd_next[NSRC-1:0] = live;
      AW'(OFS_KIND): rd_next[NSRC-1:0] = kind;
      AW'(OFS_PHI):  rd_next[NSRC-1:0] = pol_hi;
      AW'(OFS_PLO):  rd_next[NSRC-1:0] = pol_lo;
      AW'(OFS_ON):   rd_next[NSRC-1:0] = en;
      AW'(OFS_HELD): rd_next[NSRC-1:0] = held;
      default:       rd_next = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rdata <= '0;
    else if (re) rdata <= rd_next;
    else         rdata <= '0;
  end

endmodule

// File: rtl/pirq_detect.sv
module pirq_detect #(
  parameter int unsigned NSRC = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_in,
  input  logic [NSRC-1:0] kind,
  input  logic [NSRC-1:0] pol_hi,
  input  logic [NSRC-1:0] pol_lo,
  input  logic [NSRC-1:0] en,
  output logic [NSRC-1:0] live,
  output logic [NSRC-1:0] hit
);
  import pirq_pkg::*;

  logic [NSRC-1:0] prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live <= '0;
      prev <= '0;
    end else begin
      live <= src_in;
      prev <= live;
    end
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    assign hit[i] = en[i] & src_fire(kind[i], pol_hi[i], pol_lo[i],
                                     live[i], prev[i]);
  end

endmodule

// File: rtl/pirq_hold.sv
module pirq_hold #(
  parameter int unsigned NSRC = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] hit,
  input  logic [NSRC-1:0] ack,
  output logic [NSRC-1:0] held
);
  import pirq_pkg::*;

  for (genvar i = 0; i < NSRC; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) held[i] <= 1'b0;
      else        held[i] <= hold_next(hit[i], ack[i], held[i]);
    end
  end

endmodule

// File: rtl/pirq_status.sv
module pirq_status #(
  parameter int unsigned NSRC = 8,
  parameter int unsigned DW   = 8,
  parameter int unsigned AW   = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_in,
  input  logic [AW-1:0]   bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  input  logic            bus_we,
  input  logic            bus_re,
  output logic [DW-1:0]   bus_rdata,
  output logic            irq_out
);
  logic [NSRC-1:0] kind_q, phi_q, plo_q, en_q;
  logic [NSRC-1:0] live_q, held_q;
  logic [NSRC-1:0] hit_w, ack_w;

  pirq_regs #(.NSRC(NSRC), .DW(DW), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wdata(bus_wdata),
    .we(bus_we), .re(bus_re), .live(live_q), .held(held_q),
    .rdata(bus_rdata), .kind(kind_q), .pol_hi(phi_q), .pol_lo(plo_q),
    .en(en_q), .ack(ack_w)
  );

  pirq_detect #(.NSRC(NSRC)) u_det (
    .clk(clk), .rst_n(rst_n), .src_in(src_in), .kind(kind_q),
    .pol_hi(phi_q), .pol_lo(plo_q), .en(en_q), .live(live_q), .hit(hit_w)
  );

  pirq_hold #(.NSRC(NSRC)) u_hold (
    .clk(clk), .rst_n(rst_n), .hit(hit_w), .ack(ack_w), .held(held_q)
  );

  assign irq_out = |(held_q & en_q);

endmodule

// File: rtl/pirq_checker.sv
module pirq_checker #(
  parameter int unsigned NSRC = 8,
  parameter int unsigned DW   = 8,
  parameter int unsigned AW   = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic [AW-1:0]   bus_addr,
  input logic [DW-1:0]   bus_wdata,
  input logic            bus_we,
  input logic            bus_re,
  input logic [DW-1:0]   bus_rdata,
  input logic            irq_out,
  input logic [NSRC-1:0] en_q,
  input logic [NSRC-1:0] held_q,
  input logic [NSRC-1:0] hit_w
);
  import pirq_pkg::*;

  AST_NO_LATCH_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((held_q & ~$past(held_q) & ~$past(en_q)) == '0)); // R7

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == AW'(OFS_ACK)) |=>
      ((held_q & $past(bus_wdata[NSRC-1:0]) & ~$past(hit_w)) == '0)); // R8

  AST_EN_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == AW'(OFS_ON)) |=>
      ((en_q & $past(bus_wdata[NSRC-1:0])) == $past(bus_wdata[NSRC-1:0]))); // R3

  AST_EN_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == AW'(OFS_OFF)) |=>
      ((en_q & $past(bus_wdata[NSRC-1:0])) == '0)); // R3

  AST_RDATA_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_re |=> (bus_rdata == '0)); // R4

  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |-> !irq_out); // R9

  AST_UNDEF_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && bus_addr == AW'(8'h17)) |=> (bus_rdata == '0)); // R10

endmodule

bind pirq_status pirq_checker #(.NSRC(NSRC), .DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
  .irq_out(irq_out), .en_q(en_q), .held_q(held_q), .hit_w(hit_w)
);

// File: tb/sim_pirq_status.sv
`timescale 1ns/1ps
module sim_pirq_status;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] src_in = 8'h00;
  logic [7:0] bus_addr = 8'h00;
  logic [7:0] bus_wdata = 8'h00;
  logic       bus_we = 1'b0;
  logic       bus_re = 1'b0;
  logic [7:0] bus_rdata;
  logic       irq_out;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pirq_status u0 (
    .clk(clk), .rst_n(rst_n), .src_in(src_in), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_re(bus_re),
    .bus_rdata(bus_rdata), .irq_out(irq_out)
  );

  // Behavioural reference model
  bit [7:0] m_kind, m_hi, m_lo, m_en, m_held, m_sq, m_sp, m_rd;
  bit [7:0] n_held;
  bit       c, p, fire;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_kind = 0; m_hi = 0; m_lo = 0; m_en = 0; m_held = 0;
      m_sq = 0; m_sp = 0; m_rd = 0;
    end else begin
      m_rd = 0;
      if (bus_re) begin
        if (bus_addr == 8'h10) m_rd = m_sq;
        else if (bus_addr == 8'h11) m_rd = m_kind;
        else if (bus_addr == 8'h12) m_rd = m_hi;
        else if (bus_addr == 8'h13) m_rd = m_lo;
        else if (bus_addr == 8'h15) m_rd = m_en;
        else if (bus_addr == 8'h18) m_rd = m_held;
      end
      n_held = m_held;
      for (int i = 0; i < 8; i++) begin
        c = m_sq[i]; p = m_sp[i]; fire = 0;
        if (m_en[i]) begin
          if (m_kind[i]) fire = (m_hi[i] && c && !p) || (m_lo[i] && !c && p);
          else if (m_hi[i]) fire = c;
          else if (m_lo[i]) fire = !c;
        end
        if (fire) n_held[i] = 1;
        else if (bus_we && bus_addr == 8'h14 && bus_wdata[i]) n_held[i] = 0;
      end
      m_held = n_held;
      if (bus_we) begin
        case (bus_addr)
          8'h11: m_kind = bus_wdata;
          8'h12: m_hi = bus_wdata;
          8'h13: m_lo = bus_wdata;
          8'h15: m_en = m_en | bus_wdata;
          8'h16: m_en = m_en & ~bus_wdata;
          default: ;
        endcase
      end
      m_sp = m_sq;
      m_sq = src_in;
    end
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // Every-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R9 irq_out vs model", {7'd0, irq_out}, {7'd0, |(m_held & m_en)});
      chk("R4 rdata vs model", bus_rdata, m_rd);
    end
  end

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] v);
    bus_re = 1; bus_addr = a;
    @(negedge clk);
    bus_re = 0;
    v = bus_rdata;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic rchk(input string tag, input logic [7:0] a, input logic [7:0] exp);
    logic [7:0] v;
    rd(a, v);
    chk(tag, v, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 irq after reset", {7'd0, irq_out}, 8'h00);
    chk("R1 rdata after reset", bus_rdata, 8'h00);
    rst_n = 1;
    @(negedge clk);
    rchk("R1 enable reset", 8'h15, 8'h00);
    rchk("R1 latch reset", 8'h18, 8'h00);
    rchk("R1 kind reset", 8'h11, 8'h00);
    rchk("R1 high pol reset", 8'h12, 8'h00);
    rchk("R1 low pol reset", 8'h13, 8'h00);

    src_in = 8'h22;
    wr(8'h11, 8'h0F); wr(8'h12, 8'hD5); wr(8'h13, 8'h26);
    rchk("R2 kind readback", 8'h11, 8'h0F);
    rchk("R2 high pol readback", 8'h12, 8'hD5);
    rchk("R2 low pol readback", 8'h13, 8'h26);

    wr(8'h14, 8'hFF); wr(8'h15, 8'h3F);
    rchk("R3 enable bitmap", 8'h15, 8'h3F);
    settle();
    rchk("R8 no latches", 8'h18, 8'h00);
    chk("R9 irq idle", {7'd0, irq_out}, 8'h00);
    rchk("R4 live status", 8'h10, 8'h22);

    src_in = 8'h23; settle();
    rchk("R5 rising edge latch", 8'h18, 8'h01);
    chk("R9 irq on latch", {7'd0, irq_out}, 8'h01);
    wr(8'h14, 8'h01); settle();
    rchk("R8 edge latch cleared", 8'h18, 8'h00);
    chk("R9 irq after clear", {7'd0, irq_out}, 8'h00);

    src_in = 8'h21; settle();
    rchk("R5 falling edge latch", 8'h18, 8'h02);
    wr(8'h14, 8'h02);
    src_in = 8'h25; settle();
    rchk("R5 both-edge rise", 8'h18, 8'h04);
    wr(8'h14, 8'h04);
    src_in = 8'h21; settle();
    rchk("R5 both-edge fall", 8'h18, 8'h04);
    wr(8'h14, 8'h04);
    src_in = 8'h29; settle();
    src_in = 8'h21; settle();
    rchk("R5 edge with no polarity", 8'h18, 8'h00);
    src_in = 8'h20; settle();
    rchk("R5 rising-only ignores fall", 8'h18, 8'h00);

    src_in = 8'h30; settle();
    rchk("R6 level high latch", 8'h18, 8'h10);
    wr(8'h14, 8'h10); settle();
    rchk("R6 clear while active", 8'h18, 8'h10);
    src_in = 8'h20; settle();
    wr(8'h14, 8'h10); settle();
    rchk("R6 clear after level drop", 8'h18, 8'h00);
    src_in = 8'h00; settle();
    rchk("R6 level low latch", 8'h18, 8'h20);
    src_in = 8'h20; settle();
    rchk("R6 level latch retained", 8'h18, 8'h20);
    wr(8'h14, 8'h20); settle();
    rchk("R8 level latch cleared", 8'h18, 8'h00);

    src_in = 8'h60; settle();
    rchk("R7 disabled source no latch", 8'h18, 8'h00);
    chk("R7 irq disabled", {7'd0, irq_out}, 8'h00);
    wr(8'h15, 8'h40); settle();
    rchk("R7 latch after enable", 8'h18, 8'h40);
    chk("R9 irq enabled latch", {7'd0, irq_out}, 8'h01);
    wr(8'h16, 8'h40);
    rchk("R3 enable cleared", 8'h15, 8'h3F);
    chk("R9 irq masked", {7'd0, irq_out}, 8'h00);
    rchk("R7 latch kept when disabled", 8'h18, 8'h40);
    src_in = 8'h20; settle();
    wr(8'h14, 8'h40);

    src_in = 8'h21; settle();
    rchk("R11 stale latch taken", 8'h18, 8'h01);
    wr(8'h16, 8'h01);
    rchk("R11 source disabled", 8'h15, 8'h3E);
    wr(8'h14, 8'h01); wr(8'h15, 8'h01);
    chk("R11 no stale interrupt", {7'd0, irq_out}, 8'h00);
    settle();
    chk("R11 still quiet", {7'd0, irq_out}, 8'h00);
    rchk("R11 latch empty", 8'h18, 8'h00);
    rchk("R11 enable restored", 8'h15, 8'h3F);

    rchk("R10 undefined 0x17 reads zero", 8'h17, 8'h00);
    rchk("R10 enable-clear reads zero", 8'h16, 8'h00);
    rchk("R10 latch-clear reads zero", 8'h14, 8'h00);
    rchk("R10 far offset reads zero", 8'h00, 8'h00);
    wr(8'h10, 8'hFF); wr(8'h18, 8'hFF); wr(8'h17, 8'hFF); wr(8'h00, 8'hFF);
    settle();
    rchk("R10 live unchanged", 8'h10, 8'h21);
    rchk("R10 latch unchanged", 8'h18, 8'h00);
    rchk("R10 kind unchanged", 8'h11, 8'h0F);
    rchk("R10 enable unchanged", 8'h15, 8'h3F);
    @(negedge clk);
    chk("R4 rdata zero when idle", bus_rdata, 8'h00);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule